// File: doc/BRIEF.md
# Transactional Commit/Cancel FIFO

A single-clock FIFO in which both the producer and the consumer work in batches. Entries the producer writes are held back from the consumer until the producer publishes them. The producer can instead abandon the batch, and the FIFO then behaves as if none of those writes had been made. On the consumer side reads are tentative. The consumer either makes them final, which frees the storage for new writes, or rewinds, which presents the same entries again from the first read of the batch.

Each side holds two pointers. The working pointer moves with every accepted operation. The committed pointer moves only when the batch is published. A commit copies the working pointer into the committed one, and a cancel copies the committed pointer back into the working one. `full` compares the producer's working pointer with the consumer's committed pointer, so space a reader has not yet released is never reused. `empty` compares the consumer's working pointer with the producer's committed pointer, so unpublished data is never exposed. Each pointer carries one wrap bit above the address bits, and the depth is a power of two. The read port is first-word-fall-through: `rd_data` shows the entry at the consumer's working position whenever `empty` is low.

Top module: `txn_fifo`

## Requirements
- R1: A synchronous active-high `rst` clears all four pointers, which gives `empty`=1 and `full`=0 after the first clock edge with `rst` high.
- R2: Writes not yet published leave `empty` unchanged. A FIFO that is empty stays empty while only uncommitted writes are made.
- R3: `wr_commit` publishes every write accepted since the last write commit or cancel, including a write accepted in the commit cycle. From the next cycle those entries are readable.
- R4: `wr_cancel` discards every write accepted since the last write commit or cancel, including a write in the same cycle. When `wr_cancel` and `wr_commit` are both high, the cancel takes effect.
- R5: `rd_data` presents the oldest unread entry whenever `empty`=0, and each read accepted with `rd_en` advances to the next entry in write order.
- R6: `rd_cancel` rewinds the read position to the last committed read position, so the same entries are presented again. When `rd_cancel` and `rd_commit` are both high, the cancel takes effect.
- R7: Space is freed only by `rd_commit`. `full` stays 1 after all entries of a full FIFO have been read, until a read commit.
- R8: `full`=1 when 2**ADDR_W entries lie between the read committed and write working positions. `wr_en` while full is ignored and stores nothing.
- R9: `rd_en` while `empty`=1 is ignored and does not move the read position.
- R10: A read accepted in the same cycle as `rd_commit` is part of that commit, and a later `rd_cancel` does not return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_commit | input | 1 | Publish the pending writes |
| wr_cancel | input | 1 | Discard the pending writes |
| full | output | 1 | No free entry for the producer |
| rd_en | input | 1 | Read request (advance) |
| rd_data | output | DATA_W | Entry at the read position |
| rd_commit | input | 1 | Make pending reads final |
| rd_cancel | input | 1 | Rewind pending reads |
| empty | output | 1 | No published entry to read |

## Verification
Commit and cancel on the same side can arrive in the same cycle, and so can a data operation and a commit. The bench drives a write together with both `wr_commit` and `wr_cancel`, then publishes a single fresh entry and checks that exactly that entry appears first. The discarded data must not show up and the read must not skip ahead. On the read side it raises `rd_cancel` and `rd_commit` together after two reads and expects the first entry again. It also folds the last read into an `rd_commit` and expects a following `rd_cancel` to leave the FIFO empty.

// File: rtl/txf_pkg.sv
package txf_pkg;

    // Per-side transaction controls after qualification by the flags
    typedef struct packed {
        logic step;    // accepted data operation this cycle
        logic commit;  // publish working position
        logic cancel;  // roll working position back
    } txn_ctl_t;

endpackage

// File: rtl/txf_ptr_pair.sv
module txf_ptr_pair
    import txf_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  txn_ctl_t         ctl,
    output logic [PTR_W-1:0] work,
    output logic [PTR_W-1:0] cmt
);

    typedef struct packed {
        logic [PTR_W-1:0] work;
        logic [PTR_W-1:0] cmt;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        logic [PTR_W-1:0] adv;
        st_d = st_q;
        adv  = st_q.work + PTR_W'(ctl.step);
        if (ctl.cancel) begin
            st_d.work = st_q.cmt;
        end else if (ctl.commit) begin
            st_d.work = adv;
            st_d.cmt  = adv;
        end else begin
            st_d.work = adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign work = st_q.work;
    assign cmt  = st_q.cmt;

    // R3 / R6: committed position only moves on a commit without cancel
    p_cmt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctl.commit || ctl.cancel) |=> $stable(cmt));

    // R4 / R6: a cancel returns the working position to the committed one
    p_rollback_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.cancel |=> (work == $past(cmt)));

endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/txn_fifo.sv
module txn_fifo
    import txf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              wr_cancel,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_commit,
    input  logic              rd_cancel,
    output logic              empty
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] WRAP = PTR_W'(1) << ADDR_W;

    logic [PTR_W-1:0] wp_work, wp_cmt, rp_work, rp_cmt;
    txn_ctl_t wctl, rctl;
    logic wr_ok, rd_ok;

    // Flags: producer working vs consumer committed, consumer working vs producer committed
    assign full  = ((wp_work ^ rp_cmt) == WRAP);
    assign empty = (rp_work == wp_cmt);

    assign wr_ok = wr_en && !full;
    assign rd_ok = rd_en && !empty;

    always_comb begin
        wctl        = '0;
        wctl.step   = wr_ok;
        wctl.commit = wr_commit;
        wctl.cancel = wr_cancel;
        rctl        = '0;
        rctl.step   = rd_ok;
        rctl.commit = rd_commit;
        rctl.cancel = rd_cancel;
    end

    txf_ptr_pair #(.PTR_W(PTR_W)) u_wside (
        .clk (clk), .rst (rst), .ctl (wctl),
        .work(wp_work), .cmt (wp_cmt)
    );

    txf_ptr_pair #(.PTR_W(PTR_W)) u_rside (
        .clk (clk), .rst (rst), .ctl (rctl),
        .work(rp_work), .cmt (rp_cmt)
    );

    txf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (wr_ok),
        .waddr(wp_work[ADDR_W-1:0]),
        .wdata(wr_data),
        .raddr(rp_work[ADDR_W-1:0]),
        .rdata(rd_data)
    );

    // R8: producer never runs more than DEPTH ahead of released space
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (PTR_W'(wp_work - rp_cmt) <= PTR_W'(DEPTH)));

    // R9: consumer never passes the published write position
    p_no_underrun_r9: assert property (@(posedge clk) disable iff (rst)
        (PTR_W'(wp_cmt - rp_work) <= PTR_W'(DEPTH)));

    // R2: without a write commit or read rewind an empty FIFO stays empty
    p_hidden_r2: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_commit && !rd_cancel) |=> empty);

    // R7: without a read commit or write rollback a full FIFO stays full
    p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_commit && !wr_cancel) |=> full);

endmodule

// File: tb/tb_txn_fifo.sv
`timescale 1ns/1ps
module tb_txn_fifo;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_commit = 0, wr_cancel = 0;
    logic rd_en = 0, rd_commit = 0, rd_cancel = 0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic full, empty;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    txn_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_commit(wr_commit), .wr_cancel(wr_cancel),
        .full(full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_commit(rd_commit), .rd_cancel(rd_cancel),
        .empty(empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one cycle of controls, then sample 1 ns after the edge
    task automatic cyc(input bit we, input logic [DATA_W-1:0] wd, input bit wc, input bit wx,
                       input bit re, input bit rc, input bit rx);
        wr_en = we; wr_data = wd; wr_commit = wc; wr_cancel = wx;
        rd_en = re; rd_commit = rc; rd_cancel = rx;
        @(posedge clk); #1;
        wr_en = 0; wr_commit = 0; wr_cancel = 0;
        rd_en = 0; rd_commit = 0; rd_cancel = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst = 1'b0;
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);
    endtask

    task automatic t_publish();
        for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
        check(empty == 1'b1, "R2 hidden", empty, 1);
        cyc(1, 8'h13, 1, 0, 0, 0, 0);
        check(empty == 1'b0, "R3 published", empty, 0);
        for (int i = 0; i < 4; i++) begin
            check(rd_data == 8'h10 + 8'(i), "R5 order", rd_data, 8'h10 + i);
            cyc(0, 0, 0, 0, 1, (i == 3), 0);
        end
        check(empty == 1'b1, "R3 drained", empty, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        check(empty == 1'b1, "R10 read in commit cycle kept", empty, 1);
    endtask

    task automatic t_wcancel();
        cyc(1, 8'h20, 0, 0, 0, 0, 0);
        cyc(1, 8'h21, 0, 0, 0, 0, 0);
        cyc(1, 8'h22, 1, 1, 0, 0, 0);
        check(empty == 1'b1, "R4 cancel wins", empty, 1);
        cyc(1, 8'h30, 1, 0, 0, 0, 0);
        check(rd_data == 8'h30, "R4 discarded data", rd_data, 8'h30);
        cyc(0, 0, 0, 0, 1, 1, 0);
        check(empty == 1'b1, "R4 only one entry", empty, 1);
    endtask

    task automatic t_rcancel();
        cyc(1, 8'h40, 0, 0, 0, 0, 0);
        cyc(1, 8'h41, 0, 0, 0, 0, 0);
        cyc(1, 8'h42, 1, 0, 0, 0, 0);
        check(rd_data == 8'h40, "R5 first", rd_data, 8'h40);
        cyc(0, 0, 0, 0, 1, 0, 0);
        check(rd_data == 8'h41, "R5 second", rd_data, 8'h41);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        check(rd_data == 8'h40, "R6 rewind, cancel wins", rd_data, 8'h40);
        for (int i = 0; i < 3; i++) begin
            check(rd_data == 8'h40 + 8'(i), "R6 replay", rd_data, 8'h40 + i);
            cyc(0, 0, 0, 0, 1, (i == 2), 0);
        end
        check(empty == 1'b1, "R6 drained", empty, 1);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'h50 + 8'(i), 0, 0, 0, 0, 0);
        check(full == 1'b1, "R8 full on working pointer", full, 1);
        check(empty == 1'b1, "R2 full but unpublished", empty, 1);
        cyc(1, 8'hEE, 1, 0, 0, 0, 0);
        check(full == 1'b1, "R8 still full", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            check(rd_data == 8'h50 + 8'(i), "R8 no overwrite", rd_data, 8'h50 + i);
            cyc(0, 0, 0, 0, 1, 0, 0);
        end
        check(empty == 1'b1, "R8 extra write ignored", empty, 1);
        check(full == 1'b1, "R7 held until read commit", full, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        check(full == 1'b0, "R7 freed", full, 0);
    endtask

    task automatic t_empty_read();
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 0);
        check(empty == 1'b1, "R9 empty", empty, 1);
        cyc(1, 8'h60, 1, 0, 0, 0, 0);
        check(rd_data == 8'h60, "R9 read position unmoved", rd_data, 8'h60);
        check(empty == 1'b0, "R9 not empty", empty, 0);
        cyc(0, 0, 0, 0, 1, 1, 0);
        check(empty == 1'b1, "R9 drained", empty, 1);
    endtask

    initial begin
        t_reset();
        t_publish();
        t_wcancel();
        t_rcancel();
        t_full();
        t_empty_read();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule